// File: doc/BRIEF.md
# Stereo Tremolo with Phase Toggle

This block applies amplitude modulation to a stereo audio stream. On each sample strobe it takes a signed left sample, a signed right sample and an unsigned modulation level from an external low-frequency oscillator. It multiplies each sample by a level and keeps the upper half of the product. The left channel always sees the level as given. The right channel sees either the same level (in-phase tremolo) or its bitwise inverse (ping-pong tremolo, where the sound swings between the two sides).

A single mode bit chooses between the two behaviours. An active-low pushbutton flips that bit once per press. The button passes through a two-flop synchroniser and is examined only at decision instants. A decision instant is every `DECIM`-th sample strobe, counted from reset. A pressed-latch flag makes sure that holding the button down flips the mode only once.

Top module: `stereo_tremolo`

## Requirements
- R1: On a strobe, `leftOut` becomes bits [SAMPLE_W+LEVEL_W-1 : LEVEL_W] of the product of `leftIn` (two's complement) and `lfoLevel` (unsigned).
- R2: When the mode bit is 0, `rightOut` becomes the same upper slice of `rightIn` (signed) times `lfoLevel` (unsigned).
- R3: When the mode bit is 1, `rightOut` uses the bitwise inverse of `lfoLevel` in place of the level. An all-ones level then gives 0.
- R4: After reset, both outputs are 0 and the mode bit is 0.
- R5: Each output takes its new value on the clock edge that samples `sampleStrobe` high. Without a strobe, both outputs hold their values.
- R6: At a decision instant, a pressed button (`buttonN` = 0) toggles the mode only if the pressed latch is clear, and it then sets the latch. Holding the button across later instants causes no further toggles.
- R7: At a decision instant, a released button (`buttonN` = 1) clears the latch, so the next press toggles the mode again.
- R8: The button is examined only at decision instants. A decision instant is a strobe whose zero-based index since reset is congruent to DECIM-1 modulo DECIM. A press that is released before the next decision instant has no effect. The mode change applies from the strobe after that instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One-cycle pulse marking a new stereo sample |
| leftIn | input | SAMPLE_W | Signed left sample |
| rightIn | input | SAMPLE_W | Signed right sample |
| lfoLevel | input | LEVEL_W | Unsigned modulation level |
| buttonN | input | 1 | Active-low mode pushbutton, asynchronous |
| leftOut | output | SAMPLE_W | Modulated left sample |
| rightOut | output | SAMPLE_W | Modulated right sample |

## Verification
The bench builds the block with SAMPLE_W = 8, LEVEL_W = 8 and DECIM = 4. With 8-bit operands, every pairing of sample and level, 65,536 in all, can be swept in the inverting mode, so both multiplier slices are covered completely. With a decimation of 4, decision instants come often enough to script short presses, held presses and repeated presses, each timed against a strobe count that the bench tracks itself.

// File: rtl/trem_pkg.sv
package trem_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new stereo sample this cycle
    logic invert;  // right channel uses inverted level
  } trem_ctrl_t;
endpackage

// File: rtl/trem_ctrl.sv
module trem_ctrl
  import trem_pkg::*;
#(
  parameter int DECIM = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStrobe,
  input  logic       buttonN,
  output trem_ctrl_t ctrlOut
);
  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECIM - 1);

  logic [1:0]       btnSync;
  logic             btnNow;
  logic [CNT_W-1:0] strobeCnt;
  logic             decide;
  logic             pressLatch;
  logic             modeBit;

  // two-flop synchroniser, resets to released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) btnSync <= 2'b11;
    else       btnSync <= {btnSync[0], buttonN};
  end
  assign btnNow = btnSync[1];

  // strobe counter defines the decision instants
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeCnt <= '0;
    else if (sampleStrobe) begin
      if (strobeCnt == CNT_LAST) strobeCnt <= '0;
      else                       strobeCnt <= strobeCnt + 1'b1;
    end
  end
  assign decide = sampleStrobe && (strobeCnt == CNT_LAST);

  // press latch and mode toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pressLatch <= 1'b0;
      modeBit    <= 1'b0;
    end else if (decide) begin
      if (btnNow) begin
        pressLatch <= 1'b0;
      end else if (!pressLatch) begin
        pressLatch <= 1'b1;
        modeBit    <= ~modeBit;
      end
    end
  end

  assign ctrlOut.load   = sampleStrobe;
  assign ctrlOut.invert = modeBit;

  AST_MODE_AT_INSTANT: assert property (@(posedge clk) disable iff (!rstN)
    !decide |=> $stable(modeBit)); // R8
  AST_HOLD_NO_RETOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (decide && pressLatch) |=> $stable(modeBit)); // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (decide && btnNow) |=> !pressLatch); // R7
endmodule

// File: rtl/trem_datapath.sv
module trem_datapath
  import trem_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  trem_ctrl_t          ctrlIn,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic [LEVEL_W-1:0]  lfoLevel,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);
  localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
  localparam int TOP_B  = SAMPLE_W + LEVEL_W - 1;

  logic [LEVEL_W-1:0]       rightLevel;
  logic signed [PROD_W-1:0] prodLeft;
  logic signed [PROD_W-1:0] prodRight;

  // ones complement keeps the inverted level inside range
  assign rightLevel = ctrlIn.invert ? ~lfoLevel : lfoLevel;

  assign prodLeft  = $signed(leftIn)  * $signed({1'b0, lfoLevel});
  assign prodRight = $signed(rightIn) * $signed({1'b0, rightLevel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftOut  <= '0;
      rightOut <= '0;
    end else if (ctrlIn.load) begin
      leftOut  <= prodLeft[TOP_B -: SAMPLE_W];
      rightOut <= prodRight[TOP_B -: SAMPLE_W];
    end
  end

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.load |=> ($stable(leftOut) && $stable(rightOut))); // R5
  AST_ZERO_SAMPLE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && leftIn == '0) |=> (leftOut == '0)); // R1
  AST_FULL_LEVEL_INVERTED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && ctrlIn.invert && (&lfoLevel)) |=> (rightOut == '0)); // R3
  AST_ZERO_LEVEL_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && !ctrlIn.invert && lfoLevel == '0) |=> (rightOut == '0)); // R2
endmodule

// File: rtl/stereo_tremolo.sv
module stereo_tremolo
  import trem_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 16,
  parameter int DECIM    = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStrobe,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic [LEVEL_W-1:0]  lfoLevel,
  input  logic                buttonN,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);
  trem_ctrl_t ctrlBus;

  trem_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .buttonN      (buttonN),
    .ctrlOut      (ctrlBus)
  );

  trem_datapath #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .lfoLevel (lfoLevel),
    .leftOut  (leftOut),
    .rightOut (rightOut)
  );
endmodule

// File: tb/sim_stereo_tremolo.sv
`timescale 1ns/1ps
module sim_stereo_tremolo;
  localparam int SW = 8;
  localparam int LW = 8;
  localparam int DC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [SW-1:0] leftIn = '0;
  logic [SW-1:0] rightIn = '0;
  logic [LW-1:0] lfoLevel = '0;
  logic buttonN = 1'b1;
  logic [SW-1:0] leftOut;
  logic [SW-1:0] rightOut;

  int total = 0;
  int bad = 0;
  int strobeIdx = 0;
  bit modeExp = 1'b0;
  bit latchExp = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  stereo_tremolo #(.SAMPLE_W(SW), .LEVEL_W(LW), .DECIM(DC)) u0 (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .leftIn(leftIn), .rightIn(rightIn), .lfoLevel(lfoLevel),
    .buttonN(buttonN), .leftOut(leftOut), .rightOut(rightOut)
  );

  function automatic logic [SW-1:0] scaleOf(logic [SW-1:0] s, logic [LW-1:0] l);
    int sa;
    int p;
    sa = $signed(s);
    p = sa * int'(l);
    p = p >>> LW;
    return p[SW-1:0];
  endfunction

  task automatic check(string tag, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one strobe, then check both outputs against the bench model
  task automatic pulse(logic [SW-1:0] l, logic [SW-1:0] r, logic [LW-1:0] lv, string tag);
    logic [SW-1:0] expL;
    logic [SW-1:0] expR;
    expL = scaleOf(l, lv);
    expR = scaleOf(r, modeExp ? ~lv : lv);
    leftIn = l; rightIn = r; lfoLevel = lv; sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    check("R1", "left", leftOut, expL);
    check(tag, "right", rightOut, expR);
    // decision instant model (button settled well before)
    if ((strobeIdx % DC) == DC - 1) begin
      if (buttonN) latchExp = 1'b0;
      else if (!latchExp) begin latchExp = 1'b1; modeExp = ~modeExp; end
    end
    strobeIdx++;
  endtask

  task automatic setButton(logic v);
    buttonN = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic alignToInstantStart(string tag);
    while ((strobeIdx % DC) != 0) pulse(8'h40, 8'h40, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    check("R4", "left reset", leftOut, '0);
    check("R4", "right reset", rightOut, '0);
    // R4 mode 0 after reset: inverted level would give nonzero here
    pulse(8'h40, 8'h40, 8'h00, "R4");

    // R2 direct mode, assorted patterns
    pulse(8'h7F, 8'h80, 8'hFF, "R2");
    pulse(8'h80, 8'h7F, 8'h80, "R2");
    pulse(8'hFF, 8'h01, 8'h01, "R2");
    pulse(8'h33, 8'hC5, 8'h9A, "R2");

    // R5 hold without strobe
    leftIn = 8'h11; rightIn = 8'h22; lfoLevel = 8'hEE;
    repeat (3) @(negedge clk);
    check("R5", "left hold", leftOut, scaleOf(8'h33, 8'h9A));
    check("R5", "right hold", rightOut, scaleOf(8'hC5, 8'h9A));

    // R8 short press between decision instants: no effect
    alignToInstantStart("R8");
    setButton(1'b0);
    pulse(8'h40, 8'h40, 8'h00, "R8");
    setButton(1'b1);
    for (int i = 0; i < 2 * DC; i++) pulse(8'h40, 8'h40, 8'h00, "R8");

    // R6 press held over three instants toggles once
    setButton(1'b0);
    for (int i = 0; i < 3 * DC; i++) pulse(8'h40, 8'h40, 8'h00, "R6");
    check("R6", "right in inverted mode", rightOut, scaleOf(8'h40, 8'hFF));

    // R7 release then press again toggles back, then once more
    setButton(1'b1);
    for (int i = 0; i < DC; i++) pulse(8'h40, 8'h40, 8'h00, "R7");
    setButton(1'b0);
    for (int i = 0; i < DC + 1; i++) pulse(8'h40, 8'h40, 8'h00, "R7");
    check("R7", "right back in direct mode", rightOut, 8'h00);
    setButton(1'b1);
    for (int i = 0; i < DC; i++) pulse(8'h40, 8'h40, 8'h00, "R7");
    setButton(1'b0);
    for (int i = 0; i < DC + 1; i++) pulse(8'h40, 8'h40, 8'h00, "R7");
    setButton(1'b1);
    for (int i = 0; i < DC; i++) pulse(8'h40, 8'h40, 8'h00, "R7");

    // R3 and R1 exhaustive sweep in inverted mode
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        pulse(a[7:0], a[7:0] ^ 8'h5A, b[7:0], "R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule